// File: doc/BRIEF.md
# PRG Bank Mask-and-Offset Composer

This combinational block forms the final 8 KiB program-memory page number for one CPU window of a bank-switching cartridge controller. It takes three inputs:

- the page value that an inner bank-switching core has already chosen for that window;
- the two CPU address bits that name the window;
- the inner core's command bit 6, which swaps its page slots.

Three outer configuration bytes then decide, bit by bit, whether each upper page bit keeps the inner core's value or takes a fixed outer offset. The polarity of that choice differs from bit to bit.

A fixed-bank mode replaces the low page bits with outer fields, so that the window behaves as one 16 KiB bank or one 32 KiB bank. A separate remap option sends the inner core's last two pages to page 0 in the upper two windows, unless the inner core has swapped its slots.

The result is an 8-bit page index, which reaches 2 MiB. It follows its inputs with no register in the path. The configuration byte that carries only pattern-table controls has no effect on this path and is not an input.

Top module: `prg_bank_composer`

## Requirements
- R1: In inner mode (`cfg_m_i[4]`=0), page bits 3:0 always equal bits 3:0 of the inner value after the remap of R9.
- R2: Page bit 4 takes the inner value bit 4 while `cfg_a_i[6]`=0, and `cfg_a_i[0]` while `cfg_a_i[6]`=1.
- R3: Page bit 5 takes the inner value bit 5 while `cfg_b_i[7]`=0, and `cfg_a_i[1]` while `cfg_b_i[7]`=1.
- R4: Page bit 6 takes `cfg_a_i[2]` while `cfg_b_i[6]`=0, and the inner value bit 6 while `cfg_b_i[6]`=1.
- R5: Page bit 7 takes `cfg_b_i[4]` while `cfg_b_i[5]`=0, and the inner value bit 7 while `cfg_b_i[5]`=1.
- R6: In fixed-bank mode (`cfg_m_i[4]`=1) with `cfg_b_i[1]`=0 (16 KiB), page bits 3:1 equal `cfg_m_i[3:1]` and page bit 0 equals `win_i[0]`.
- R7: In fixed-bank mode with `cfg_b_i[1]`=1 (32 KiB), page bits 3:2 equal `cfg_m_i[3:2]`, page bit 1 equals `win_i[1]` and page bit 0 equals `win_i[0]`; `cfg_m_i[1]` has no effect.
- R8: In fixed-bank mode, page bits 7:4 follow the same selection as R2 to R5.
- R9: With `cfg_m_i[6]`=1, an inner value of 0xFE or 0xFF is replaced by 0 when `swap_i`=0 and `win_i[1]`=1 (windows `win_i`=2 or 3).
- R10: The replacement of R9 does not occur when `swap_i`=1, when `win_i[1]`=0, or when the inner value is below 0xFE.
- R11: The bits `cfg_a_i[7,5:3]`, `cfg_b_i[3:2,0]` and `cfg_m_i[7,5,0]` have no effect on `page_o`.
- R12: `page_o` reflects any input change within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inner_page_i | input | 8 | Page value chosen by the inner bank-switching core |
| win_i | input | 2 | CPU address bits A14:A13 selecting the 8 KiB window |
| swap_i | input | 1 | Inner core command bit 6 (page-slot swap) |
| cfg_a_i | input | 8 | Outer configuration byte A (offset low bits, bit-4 select) |
| cfg_b_i | input | 8 | Outer configuration byte B (offset bit, selects, bank size) |
| cfg_m_i | input | 8 | Outer mode byte (fixed-bank enable and fields, remap enable) |
| page_o | output | 8 | Composed 8 KiB page index |

## Verification
The remap of the last two pages and the fixed-bank mode can act on the same window at the same time. The remapped value must still pass through the narrowed mask while the low bits come from the fixed-bank fields. Vectors that enable both options at once, with a 0xFF inner value in an upper window, are checked against a page computed from the requirement text. Neighbouring vectors each drop one remap condition, so that the replacement is shown both applied and withheld.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int PAGE_W = 8;
  localparam int CFG_W  = 8;
  localparam int LOW_W  = 4;
  localparam int WIN_W  = 2;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [CFG_W-1:0]  cfg_t;
  localparam page_t MASK_INIT = page_t'(8'h3F);
  localparam page_t HI_ONLY   = page_t'({(PAGE_W-LOW_W){1'b1}}) << LOW_W;
endpackage

// File: rtl/prg_mask_gen.sv
module prg_mask_gen
  import prg_bank_pkg::*;
(
  input  cfg_t  cfg_a_i,
  input  cfg_t  cfg_b_i,
  output page_t mask_o
);
  // 1 = bit from inner value, 0 = bit from outer offset
  always_comb begin
    mask_o    = MASK_INIT;
    mask_o[4] = MASK_INIT[4] ^ cfg_a_i[6];
    mask_o[5] = MASK_INIT[5] ^ cfg_b_i[7];
    mask_o[6] = cfg_b_i[6];
    mask_o[7] = cfg_b_i[5];
  end

  logic unused_mask;
  assign unused_mask = ^{cfg_a_i[7], cfg_a_i[5:0], cfg_b_i[4:0]};
endmodule

// File: rtl/prg_offset_gen.sv
module prg_offset_gen
  import prg_bank_pkg::*;
(
  input  cfg_t  cfg_a_i,
  input  cfg_t  cfg_b_i,
  output page_t offset_o
);
  localparam int BASE_W = PAGE_W;
  logic [BASE_W-1:0]       base;
  logic [BASE_W+LOW_W-1:0] shifted;

  assign base     = {cfg_a_i[5:4], cfg_b_i[3:2], cfg_b_i[4], cfg_a_i[2:0]};
  assign shifted  = {base, {LOW_W{1'b0}}};
  assign offset_o = shifted[PAGE_W-1:0];

  logic unused_off;
  assign unused_off = ^{shifted[BASE_W+LOW_W-1:PAGE_W], cfg_a_i[7:6], cfg_a_i[3],
                        cfg_b_i[7:5], cfg_b_i[1:0]};
endmodule

// File: rtl/prg_tail_remap.sv
module prg_tail_remap
  import prg_bank_pkg::*;
(
  input  logic             en_i,
  input  logic             swap_i,
  input  logic [WIN_W-1:0] win_i,
  input  page_t            page_i,
  output page_t            page_o
);
  logic tail_page, hit;
  assign tail_page = &page_i[PAGE_W-1:1];
  assign hit       = en_i && tail_page && !swap_i && win_i[WIN_W-1];
  assign page_o    = hit ? '0 : page_i;
endmodule

// File: rtl/prg_bank_composer.sv
module prg_bank_composer
  import prg_bank_pkg::*;
(
  input  logic [7:0] inner_page_i,
  input  logic [1:0] win_i,
  input  logic       swap_i,
  input  logic [7:0] cfg_a_i,
  input  logic [7:0] cfg_b_i,
  input  logic [7:0] cfg_m_i,
  output logic [7:0] page_o
);
  logic fixed_en, wide32, remap_en;
  assign fixed_en = cfg_m_i[4];
  assign wide32   = cfg_b_i[1];
  assign remap_en = cfg_m_i[6];

  page_t mask_raw, mask_eff, offset, inner_eff, low_fix;

  prg_mask_gen u_mask (
    .cfg_a_i (cfg_a_i),
    .cfg_b_i (cfg_b_i),
    .mask_o  (mask_raw)
  );

  prg_offset_gen u_off (
    .cfg_a_i  (cfg_a_i),
    .cfg_b_i  (cfg_b_i),
    .offset_o (offset)
  );

  prg_tail_remap u_remap (
    .en_i   (remap_en),
    .swap_i (swap_i),
    .win_i  (win_i),
    .page_i (inner_page_i),
    .page_o (inner_eff)
  );

  assign mask_eff = fixed_en ? (mask_raw & HI_ONLY) : mask_raw;

  // fixed-bank low field, one bit per generate slice
  for (genvar i = 0; i < PAGE_W; i++) begin : g_low
    if (i == 0) begin : g_a13
      assign low_fix[i] = fixed_en & win_i[0];
    end else if (i == 1) begin : g_a14
      assign low_fix[i] = fixed_en & (wide32 ? win_i[1] : cfg_m_i[1]);
    end else if (i < LOW_W) begin : g_reg
      assign low_fix[i] = fixed_en & cfg_m_i[i];
    end else begin : g_none
      assign low_fix[i] = 1'b0;
    end
  end

  assign page_o = (offset & ~mask_eff) | (inner_eff & mask_eff) | low_fix;

  logic unused_top;
  assign unused_top = ^{cfg_m_i[7], cfg_m_i[5], cfg_m_i[0]};
endmodule

// File: rtl/prg_bank_composer_chk.sv
module prg_bank_composer_chk (
  input logic [7:0] inner_page_i,
  input logic [1:0] win_i,
  input logic       swap_i,
  input logic [7:0] cfg_a_i,
  input logic [7:0] cfg_b_i,
  input logic [7:0] cfg_m_i,
  input logic [7:0] page_o
);
  logic tail_hit;
  assign tail_hit = cfg_m_i[6] && (inner_page_i >= 8'hFE) && !swap_i && win_i[1];

  always_comb begin
    if (!cfg_m_i[4] && !cfg_m_i[6])
      p_low_pass_r1: assert (page_o[3:0] == inner_page_i[3:0]);
    if (cfg_m_i[4])
      p_bit0_a13_r6: assert (page_o[0] == win_i[0]);
    if (cfg_m_i[4] && !cfg_b_i[1])
      p_fix16_r6: assert (page_o[3:1] == cfg_m_i[3:1]);
    if (cfg_m_i[4] && cfg_b_i[1])
      p_fix32_r7: assert (page_o[3:1] == {cfg_m_i[3:2], win_i[1]});
    if (!cfg_m_i[4] && tail_hit)
      p_tail_zero_r9: assert (page_o[3:0] == 4'h0);
    if (!cfg_b_i[5])
      p_bit7_off_r5: assert (page_o[7] == cfg_b_i[4]);
    if (!cfg_b_i[6])
      p_bit6_off_r4: assert (page_o[6] == cfg_a_i[2]);
  end
endmodule

bind prg_bank_composer prg_bank_composer_chk u_chk (.*);

// File: tb/prg_bank_composer_bench.sv
`timescale 1ns/1ps
module prg_bank_composer_bench;
  logic       clk = 1'b0;
  logic [7:0] inner_page, cfg_a, cfg_b, cfg_m, page;
  logic [1:0] win;
  logic       swap;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  prg_bank_composer u_prg_bank_composer (
    .inner_page_i (inner_page),
    .win_i        (win),
    .swap_i       (swap),
    .cfg_a_i      (cfg_a),
    .cfg_b_i      (cfg_b),
    .cfg_m_i      (cfg_m),
    .page_o       (page)
  );

  // {req, cfg_a, cfg_b, cfg_m, inner, win, swap, expected}
  localparam int NV = 16;
  localparam logic [50:0] VEC [NV] = '{
    {8'd1,  8'h00, 8'h00, 8'h00, 8'h5A, 2'd0, 1'b0, 8'h1A}, // R1 default mask
    {8'd4,  8'h07, 8'h10, 8'h00, 8'h00, 2'd0, 1'b0, 8'hC0}, // R4 R5 offset bits
    {8'd4,  8'h07, 8'h50, 8'h00, 8'h00, 2'd1, 1'b0, 8'h80}, // R4 inner bit 6
    {8'd5,  8'h07, 8'h20, 8'h00, 8'h80, 2'd0, 1'b0, 8'hC0}, // R5 inner bit 7
    {8'd2,  8'h41, 8'h00, 8'h00, 8'h0F, 2'd2, 1'b0, 8'h1F}, // R2 offset bit 4
    {8'd3,  8'h02, 8'h80, 8'h00, 8'h05, 2'd3, 1'b0, 8'h25}, // R3 offset bit 5
    {8'd6,  8'h00, 8'h00, 8'h1E, 8'h20, 2'd1, 1'b0, 8'h2F}, // R6 16K
    {8'd7,  8'h00, 8'h02, 8'h1A, 8'h00, 2'd2, 1'b0, 8'h0A}, // R7 32K
    {8'd8,  8'h47, 8'h10, 8'h10, 8'h00, 2'd0, 1'b0, 8'hD0}, // R8 upper in fixed
    {8'd9,  8'h00, 8'h00, 8'h40, 8'hFE, 2'd2, 1'b0, 8'h00}, // R9 window 2
    {8'd9,  8'h00, 8'h00, 8'h40, 8'hFF, 2'd3, 1'b0, 8'h00}, // R9 window 3
    {8'd10, 8'h00, 8'h00, 8'h40, 8'hFE, 2'd2, 1'b1, 8'h3E}, // R10 swap set
    {8'd10, 8'h00, 8'h00, 8'h40, 8'hFF, 2'd1, 1'b0, 8'h3F}, // R10 low window
    {8'd10, 8'h00, 8'h00, 8'h40, 8'hFD, 2'd3, 1'b0, 8'h3D}, // R10 below FE
    {8'd9,  8'h00, 8'h20, 8'h50, 8'hFF, 2'd3, 1'b0, 8'h01}, // R9 with fixed-bank
    {8'd11, 8'hB8, 8'h0D, 8'hA1, 8'h5A, 2'd0, 1'b0, 8'h1A}  // R11 dead bits
  };

  function automatic logic [7:0] model(input logic [7:0] a, b, m, v,
                                       input logic [1:0] w, input logic s);
    logic [7:0] vv, r;
    vv = (m[6] && v >= 8'hFE && !s && w[1]) ? 8'h00 : v;           // R9 R10
    r[7] = b[5] ? vv[7] : b[4];                                      // R5
    r[6] = b[6] ? vv[6] : a[2];                                      // R4
    r[5] = b[7] ? a[1] : vv[5];                                      // R3
    r[4] = a[6] ? a[0] : vv[4];                                      // R2
    if (!m[4]) r[3:0] = vv[3:0];                                     // R1
    else if (b[1]) r[3:0] = {m[3:2], w[1], w[0]};                    // R7
    else r[3:0] = {m[3:1], w[0]};                                    // R6
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    n_run++;
    if (page !== exp) begin
      n_fail++;
      $display("FAIL %s: page_o=%h expected=%h", tag, page, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, b, m, v, input logic [1:0] w, input logic s);
    cfg_a = a; cfg_b = b; cfg_m = m; inner_page = v; win = w; swap = s;
  endtask

  initial begin
    drive(8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 1'b0);
    @(negedge clk);
    check("R1 reset state all-zero", 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      drive(VEC[i][42:35], VEC[i][34:27], VEC[i][26:19], VEC[i][18:11],
            VEC[i][10:9], VEC[i][8]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][50:43], i), VEC[i][7:0]);
    end

    // R12: change without any clock edge, observe 1 ns later
    @(negedge clk);
    drive(8'h00, 8'h00, 8'h00, 8'h33, 2'd0, 1'b0);
    #1 check("R12 same-cycle response", 8'h33);
    inner_page = 8'h0C;
    #1 check("R12 second change", 8'h0C);

    // R7: cfg_m_i[1] ignored in 32K
    drive(8'h00, 8'h02, 8'h12, 8'h00, 2'd0, 1'b0);
    #1 check("R7 bit1 ignored", 8'h00);

    // R11: toggle each dead bit alone over a live baseline
    for (int k = 0; k < 10; k++) begin
      logic [7:0] a, b, m;
      a = 8'h45; b = 8'hF2; m = 8'h5A;
      case (k)
        0: a[7] = 1'b1; 1: a[5] = 1'b1; 2: a[4] = 1'b1; 3: a[3] = 1'b1;
        4: b[3] = 1'b1; 5: b[2] = 1'b1; 6: b[0] = 1'b1;
        7: m[7] = 1'b1; 8: m[5] = 1'b1; default: m[0] = 1'b1;
      endcase
      @(posedge clk); #1;
      drive(a, b, m, 8'hC3, 2'd3, 1'b0);
      @(negedge clk);
      check($sformatf("R11 dead bit case %0d", k), model(8'h45, 8'hF2, 8'h5A, 8'hC3, 2'd3, 1'b0));
    end

    // R8 R9 mixed sweep against the requirement model
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a, b, m, v;
      logic [1:0] w;
      logic s;
      a = 8'($urandom); b = 8'($urandom); m = 8'($urandom);
      v = (n % 4 == 0) ? (8'hFE | 8'($urandom % 2)) : 8'($urandom);
      w = 2'($urandom); s = 1'($urandom);
      @(posedge clk); #1;
      drive(a, b, m, v, w, s);
      @(negedge clk);
      check($sformatf("R8 R9 sweep %0d", n), model(a, b, m, v, w, s));
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule